// File: doc/BRIEF.md
# Serial Receive Character Queue with Status

This block buffers characters arriving from a serial deserializer until a register interface reads them. Each character is stored with three error flags from the deserializer: break detected, parity error and framing error. The read side sees the oldest entry as one word that combines the character, its flags and a valid bit. A read strobe removes that entry.

The block drives four status outputs that interrupt or polling logic can use. `overrun` is set when a character arrives while the queue is full, and it stays set until the queue is reset. `above_thresh` compares the fill level with a programmable threshold. `timeout` reports that data has waited a programmed number of character times without being read. `not_empty` supports polling. A single reset control empties the queue and clears the sticky status in one cycle. A one-cycle `char_tick` strobe per character time, supplied by the baud logic, gives the timer its time base.

Top module: `rx_char_fifo`

## Requirements
- R1: The queue holds DEPTH entries (default 16) and returns them in the order they were written.
- R2: The read word is laid out with the character in bits 7:0, break in bit 8, parity error in bit 9, framing error in bit 10 and valid in bit 11. Valid is 1 whenever an entry is presented.
- R3: `level` equals the number of stored entries and `not_empty` is 1 exactly when `level` is non-zero. Both change in the cycle after the accepted write or read edge.
- R4: A write while `level` equals DEPTH is dropped, leaves the contents unchanged and sets `overrun`. This holds even when a read is made in the same cycle, in which case only the read takes effect.
- R5: `overrun` stays set through reads and further writes and is cleared only by `fifo_clr` or reset.
- R6: `above_thresh` is 1 exactly when `level` is strictly greater than `thresh`, for every threshold from 0 to DEPTH.
- R7: While the queue is non-empty, an idle counter advances on each `char_tick`. It restarts on every accepted write or read and holds at zero while the queue is empty. `timeout` is 1 when `tmo_chars` is non-zero, the counter has reached `tmo_chars` and the queue is non-empty. A `tmo_chars` of 0 disables the timeout.
- R8: `fifo_clr` takes priority over a write or read in the same cycle. After that edge, `level` is 0 and `overrun` and `timeout` are 0.
- R9: A read while the queue is empty changes no state, and the word shown while the queue is empty is all zero, with valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe from the deserializer |
| wr_char | input | 8 | Received character |
| wr_brk | input | 1 | Break detected for this character |
| wr_par | input | 1 | Parity error for this character |
| wr_frm | input | 1 | Framing error for this character |
| rd_en | input | 1 | Read strobe; pops the presented entry |
| fifo_clr | input | 1 | Queue reset control |
| thresh | input | LVL_W | Fill threshold |
| tmo_chars | input | TMO_W | Idle timeout in character times, 0 disables |
| char_tick | input | 1 | One pulse per character time |
| rd_word | output | 12 | Oldest entry with flags and valid bit |
| level | output | LVL_W | Fill level |
| not_empty | output | 1 | Queue holds data |
| overrun | output | 1 | Sticky dropped-write flag |
| above_thresh | output | 1 | Level exceeds threshold |
| timeout | output | 1 | Data idle for the programmed time |

## Verification
The bench fills the queue from empty to full and sweeps every threshold value at each level. A comparator off by one, such as `>=` in place of `>`, fails at the equal point. A write into a full queue, alone and together with a read, checks that the write is dropped and that overrun is raised. A design that let the simultaneous write through would show a level of 16 instead of 15. Reads and reads from an empty queue follow to confirm that overrun survives them and that an empty read corrupts no pointer. Timeout is run with limits of 0, 1 and 2, with writes and reads between ticks. A timer that failed to restart, or that ignored the disable setting, would assert timeout too early or at all.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int CHAR_W = 8;
    localparam int WORD_W = CHAR_W + 4;

    typedef struct packed {
        logic              frm;
        logic              par;
        logic              brk;
        logic [CHAR_W-1:0] ch;
    } rxq_entry_t;

    function automatic logic [WORD_W-1:0] rxq_word(input rxq_entry_t e, input logic vld);
        return vld ? {1'b1, e.frm, e.par, e.brk, e.ch} : '0;
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             push_req,
    input  logic             pop_req,
    input  rxq_entry_t       wr_entry,
    output rxq_entry_t       head,
    output logic [LVL_W-1:0] level,
    output logic             overrun,
    output logic             push_ok,
    output logic             pop_ok
);
    rxq_entry_t     mem [DEPTH];
    logic [AW-1:0]  wr_ptr, rd_ptr;
    logic           full, empty;

    assign full    = (level == LVL_W'(DEPTH));
    assign empty   = (level == '0);
    assign push_ok = push_req && !clr && !full;
    assign pop_ok  = pop_req && !clr && !empty;
    assign head    = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= wr_entry;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            level   <= '0;
            overrun <= 1'b0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
            level <= level + LVL_W'(push_ok) - LVL_W'(pop_ok);
            if (push_req && full) overrun <= 1'b1;
        end
    end
endmodule

// File: rtl/rxq_idle_timer.sv
module rxq_idle_timer #(
    parameter int TMO_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             active,
    input  logic             tick,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);
    logic [TMO_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart || !active)
            cnt <= '0;
        else if (tick && cnt != '1)
            cnt <= cnt + 1'b1;
    end

    assign expired = active && (limit != '0) && (cnt >= limit);
endmodule

// File: rtl/rx_char_fifo.sv
module rx_char_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int TMO_W = 4,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CHAR_W-1:0] wr_char,
    input  logic              wr_brk,
    input  logic              wr_par,
    input  logic              wr_frm,
    input  logic              rd_en,
    input  logic              fifo_clr,
    input  logic [LVL_W-1:0]  thresh,
    input  logic [TMO_W-1:0]  tmo_chars,
    input  logic              char_tick,
    output logic [WORD_W-1:0] rd_word,
    output logic [LVL_W-1:0]  level,
    output logic              not_empty,
    output logic              overrun,
    output logic              above_thresh,
    output logic              timeout
);
    rxq_entry_t in_e, head_e;
    logic       push_ok, pop_ok;

    assign in_e = '{frm: wr_frm, par: wr_par, brk: wr_brk, ch: wr_char};

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst      (rst),
        .clr      (fifo_clr),
        .push_req (wr_en),
        .pop_req  (rd_en),
        .wr_entry (in_e),
        .head     (head_e),
        .level    (level),
        .overrun  (overrun),
        .push_ok  (push_ok),
        .pop_ok   (pop_ok)
    );

    rxq_idle_timer #(.TMO_W(TMO_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (fifo_clr || push_ok || pop_ok),
        .active  (not_empty),
        .tick    (char_tick),
        .limit   (tmo_chars),
        .expired (timeout)
    );

    assign not_empty    = (level != '0);
    assign above_thresh = (level > thresh);
    assign rd_word      = rxq_word(head_e, not_empty);
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int TMO_W = 4,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic              fifo_clr,
    input logic [TMO_W-1:0]  tmo_chars,
    input logic [WORD_W-1:0] rd_word,
    input logic [LVL_W-1:0]  level,
    input logic              not_empty,
    input logic              overrun,
    input logic              timeout
);
    p_level_bound_r1: assert property (@(posedge clk) disable iff (rst)
        level <= LVL_W'(DEPTH));

    p_valid_bit_r2: assert property (@(posedge clk) disable iff (rst)
        not_empty |-> rd_word[WORD_W-1]);

    p_full_drop_r4: assert property (@(posedge clk) disable iff (rst)
        (level == LVL_W'(DEPTH) && wr_en && !rd_en && !fifo_clr)
        |=> (overrun && level == LVL_W'(DEPTH)));

    p_overrun_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (overrun && !fifo_clr) |=> overrun);

    p_timeout_data_r7: assert property (@(posedge clk) disable iff (rst)
        timeout |-> (not_empty && tmo_chars != '0));

    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
        fifo_clr |=> (level == '0 && !overrun && !timeout));

    p_empty_read_r9: assert property (@(posedge clk) disable iff (rst)
        (level == '0 && rd_en && !wr_en && !fifo_clr) |=> (level == '0));

    p_empty_word_r9: assert property (@(posedge clk) disable iff (rst)
        !not_empty |-> (rd_word == '0));
endmodule

bind rx_char_fifo rxq_checker #(.DEPTH(DEPTH), .TMO_W(TMO_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .fifo_clr  (fifo_clr),
    .tmo_chars (tmo_chars),
    .rd_word   (rd_word),
    .level     (level),
    .not_empty (not_empty),
    .overrun   (overrun),
    .timeout   (timeout)
);

// File: tb/sim_rx_char_fifo.sv
module sim_rx_char_fifo;
    localparam int DEPTH = 16;
    localparam int TMO_W = 4;
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 0, wr_brk = 0, wr_par = 0, wr_frm = 0, rd_en = 0, fifo_clr = 0, char_tick = 0;
    logic [7:0]       wr_char = '0;
    logic [LVL_W-1:0] thresh = '0;
    logic [TMO_W-1:0] tmo_chars = '0;
    logic [11:0]      rd_word;
    logic [LVL_W-1:0] level;
    logic             not_empty, overrun, above_thresh, timeout;

    int checks = 0, failures = 0;
    bit done = 0;

    logic [11:0] q [$];
    bit          m_ovr = 0;
    int          m_cnt = 0;
    int          seq = 0;

    always #5 clk = ~clk;

    rx_char_fifo #(.DEPTH(DEPTH), .TMO_W(TMO_W)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_char(wr_char), .wr_brk(wr_brk),
        .wr_par(wr_par), .wr_frm(wr_frm), .rd_en(rd_en), .fifo_clr(fifo_clr),
        .thresh(thresh), .tmo_chars(tmo_chars), .char_tick(char_tick),
        .rd_word(rd_word), .level(level), .not_empty(not_empty), .overrun(overrun),
        .above_thresh(above_thresh), .timeout(timeout)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_all();
        int lv = q.size();
        bit tmo = (tmo_chars != 0) && (m_cnt >= int'(tmo_chars)) && (lv > 0);
        chk("R3 level", int'(level), lv);
        chk("R3 not_empty", int'(not_empty), int'(lv > 0));
        chk("R5 overrun", int'(overrun), int'(m_ovr));
        chk("R7 timeout", int'(timeout), int'(tmo));
        chk("R6 above_thresh", int'(above_thresh), int'(lv > int'(thresh)));
        if (lv > 0) chk("R1 R2 head word", int'(rd_word), int'(q[0]));
        else        chk("R9 empty word", int'(rd_word), 0);
    endtask

    // One clock: inputs set after the falling edge, results sampled 1 ns after the rising edge.
    task automatic step(input bit w, input bit r, input bit c, input bit t);
        logic [11:0] nw;
        bit push, pop;
        int old;
        @(negedge clk);
        nw = {1'b1, 3'(seq % 8), 8'((seq * 53 + 11) & 255)};
        wr_en = w; rd_en = r; fifo_clr = c; char_tick = t;
        wr_char = nw[7:0]; wr_brk = nw[8]; wr_par = nw[9]; wr_frm = nw[10];
        old = q.size();
        @(posedge clk);
        #1;
        wr_en = 0; rd_en = 0; fifo_clr = 0; char_tick = 0;
        if (c) begin
            q.delete(); m_ovr = 0; m_cnt = 0;
        end else begin
            pop  = r && old > 0;
            push = w && old < DEPTH;
            if (w && old == DEPTH) m_ovr = 1;
            if (pop) void'(q.pop_front());
            if (push) begin q.push_back(nw); seq++; end
            if (push || pop || old == 0) m_cnt = 0;
            else if (t && m_cnt < 15) m_cnt++;
        end
        check_all();
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #1;
        check_all();                          // reset state

        // R6 sweep: every threshold at every level from empty to full
        for (int n = 0; n <= DEPTH; n++) begin
            for (int th = 0; th <= DEPTH; th++) begin
                thresh = LVL_W'(th); #1;
                chk("R6 thresh sweep", int'(above_thresh), int'(n > th));
            end
            thresh = LVL_W'(DEPTH / 2);
            if (n < DEPTH) step(1, 0, 0, 0);
        end
        // R4: write into full queue, then write with simultaneous read
        step(1, 0, 0, 0);
        chk("R4 overrun set on full write", int'(overrun), 1);
        step(1, 1, 0, 0);
        chk("R4 level after full write+read", int'(level), DEPTH - 1);
        // R1/R2/R5: drain with checks on each word, overrun persists
        for (int k = 0; k < DEPTH - 1; k++) step(0, 1, 0, 0);
        // R9: reads while empty
        step(0, 1, 0, 0);
        step(0, 1, 0, 1);
        chk("R5 overrun after drain", int'(overrun), 1);
        // R8: clear with simultaneous write
        step(1, 0, 1, 0);
        chk("R8 level after clear", int'(level), 0);
        // R1 wraparound ordering after partial use
        for (int k = 0; k < 10; k++) step(1, 0, 0, 0);
        for (int k = 0; k < 6; k++)  step(0, 1, 0, 0);
        for (int k = 0; k < 12; k++) step(1, 0, 0, 0);
        for (int k = 0; k < 16; k++) step(0, 1, 0, 0);

        // R7 timeout, limit 2
        tmo_chars = 4'd2;
        step(0, 0, 0, 1);                     // empty: no counting
        step(1, 0, 0, 0);
        step(0, 0, 0, 1);
        step(0, 0, 0, 0);
        step(0, 0, 0, 1);
        chk("R7 timeout after two ticks", int'(timeout), 1);
        step(1, 0, 0, 1);                     // push restarts
        chk("R7 restart on write", int'(timeout), 0);
        step(0, 0, 0, 1);
        step(0, 0, 0, 1);
        step(0, 1, 0, 1);                     // pop restarts
        step(0, 0, 0, 1);
        step(0, 0, 0, 1);
        step(0, 1, 0, 0);                     // becomes empty
        step(0, 0, 0, 1);
        // limit 1
        tmo_chars = 4'd1;
        step(1, 0, 0, 0);
        step(0, 0, 0, 1);
        chk("R7 timeout limit one", int'(timeout), 1);
        step(0, 0, 1, 0);                     // R8 clears timeout
        // limit 0 disables
        tmo_chars = 4'd0;
        step(1, 0, 0, 0);
        for (int k = 0; k < 20; k++) step(0, 0, 0, 1);
        chk("R7 disabled timeout", int'(timeout), 0);
        tmo_chars = 4'd3;
        #1;
        chk("R7 saturated count vs new limit", int'(timeout), 1);
        step(0, 0, 1, 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule